// File: doc/BRIEF.md
# Dual-Channel Sample Output Formatter

This block sits between the core of a two-channel data converter and its parallel CMOS output pads. Each channel delivers a 14-bit sample in offset binary together with two overrange flags, one for each direction. On every sample strobe the block captures both samples. It replaces any overranged sample with the full-scale code, encodes the result in the selected output format, and presents the words on two output buses.

In the normal mode, bus A carries channel A and bus B carries channel B, and both buses update together one clock after the strobe. In the interleaved mode, bus A first carries channel A and then channel B within the same sample period. A phase output tells the receiver which channel is currently on the bus. The output enable for the bus B pads is deasserted in this mode, so the pad ring places those pins in high impedance.

The format and mode selects are static controls. They are latched only on a sample strobe, so one output word never mixes two settings. The core runs at twice the sample rate whenever the interleaved mode is in use.

Top module: `adc_out_formatter`

## Requirements
- R1: In normal mode, both buses show the words captured on a strobe in the clock cycle after that strobe. They hold those words until the next strobe.
- R2: With fmt_twos low, a sample that is not overranged appears on its bus unchanged, as offset binary.
- R3: With fmt_twos high, a sample that is not overranged appears with bit 13 inverted, which is two's complement.
- R4: A sample whose positive flag alone is set is output as 0x3FFF in offset binary and as 0x1FFF in two's complement.
- R5: A sample whose negative flag alone is set is output as 0x0000 in offset binary and as 0x2000 in two's complement.
- R6: When both overrange flags of a sample are set, the positive full-scale code is output.
- R7: In interleaved mode, bus A carries channel A with mux_phase at 0 in the cycle after a strobe. From the following cycle until the next strobe it carries channel B with mux_phase at 1. In normal mode, mux_phase stays at 0.
- R8: bus_b_oe is 0 while interleaved mode is latched and 1 while normal mode is latched.
- R9: A change on fmt_twos or mux_en has no effect on any output until the next strobe, and takes effect in the cycle after that strobe.
- R10: While rst_n is low (synchronous, active low), both buses hold the mid-scale code for the fmt_twos value at reset: 0x2000 in offset binary and 0x0000 in two's complement. During reset, mux_phase is 0 and bus_b_oe is the inverse of mux_en.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; in interleaved mode its rate is twice the sample rate |
| rst_n | input | 1 | Synchronous active-low reset |
| smp_stb | input | 1 | Sample boundary strobe; captures samples and selects |
| smp_a | input | 14 | Channel A sample, offset binary |
| ovp_a | input | 1 | Channel A positive overrange |
| ovn_a | input | 1 | Channel A negative overrange |
| smp_b | input | 14 | Channel B sample, offset binary |
| ovp_b | input | 1 | Channel B positive overrange |
| ovn_b | input | 1 | Channel B negative overrange |
| fmt_twos | input | 1 | 1 selects two's complement, 0 selects offset binary |
| mux_en | input | 1 | 1 selects the interleaved single-bus mode |
| bus_a | output | 14 | Output bus A |
| bus_b | output | 14 | Output bus B data |
| bus_b_oe | output | 1 | Pad output enable for bus B |
| mux_phase | output | 1 | 0: channel A on bus A, 1: channel B on bus A |

## Verification
The situations that are hardest to reach from the ports are a select that changes between strobes and strobes that arrive on consecutive cycles in interleaved mode. In the second case the channel B half of the period never appears. The stimulus toggles fmt_twos and mux_en during gaps with no strobe and then holds them across several idle cycles. It also drives strobes in interleaved mode with gaps of zero, one and several cycles. Overrange flags are set one at a time and both together, under both formats and in both modes, and reset is applied with each combination of selects.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

   typedef enum logic {
      ENC_OFFSET = 1'b0,
      ENC_TWOS   = 1'b1
   } enc_e;

   typedef struct packed {
      enc_e enc;
      logic interleave;
   } fmt_cfg_t;

endpackage

// File: rtl/cfmt_clamp.sv
module cfmt_clamp #(
   parameter int W            = 14,
   parameter bit OVR_POS_WINS = 1'b1
) (
   input  logic [W-1:0] raw,
   input  logic         ovr_pos,
   input  logic         ovr_neg,
   output logic [W-1:0] code
);
   localparam logic [W-1:0] FS_HIGH = {W{1'b1}};
   localparam logic [W-1:0] FS_LOW  = {W{1'b0}};

   generate
      if (OVR_POS_WINS) begin : g_pos_first
         always_comb begin
            if (ovr_pos)      code = FS_HIGH;
            else if (ovr_neg) code = FS_LOW;
            else              code = raw;
         end
      end else begin : g_neg_first
         always_comb begin
            if (ovr_neg)      code = FS_LOW;
            else if (ovr_pos) code = FS_HIGH;
            else              code = raw;
         end
      end
   endgenerate
endmodule

// File: rtl/cfmt_lane.sv
module cfmt_lane #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   localparam logic [W-1:0] MID_OB = {1'b1, {(W-1){1'b0}}};

   always_ff @(posedge clk) begin
      if (!rst_n)    q <= MID_OB;
      else if (load) q <= d;
   end
endmodule

// File: rtl/cfmt_ctrl.sv
module cfmt_ctrl
   import adc_fmt_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     stb,
   input  logic     fmt_in,
   input  logic     mux_in,
   output fmt_cfg_t cfg_q,
   output logic     phase_q
);
   fmt_cfg_t cfg_d;

   always_comb begin
      cfg_d.enc        = fmt_in ? ENC_TWOS : ENC_OFFSET;
      cfg_d.interleave = mux_in;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cfg_q   <= cfg_d;
         phase_q <= 1'b0;
      end else if (stb) begin
         cfg_q   <= cfg_d;
         phase_q <= 1'b0;
      end else if (cfg_q.interleave) begin
         phase_q <= 1'b1;
      end
   end
endmodule

// File: rtl/cfmt_drive.sv
module cfmt_drive
   import adc_fmt_pkg::*;
#(
   parameter int W = 14
) (
   input  logic [W-1:0] word_a,
   input  logic [W-1:0] word_b,
   input  fmt_cfg_t     cfg,
   input  logic         phase,
   output logic [W-1:0] bus_a,
   output logic [W-1:0] bus_b,
   output logic         oe_b
);
   logic [W-1:0] flip;
   logic [W-1:0] pick_a;

   always_comb begin
      flip   = {(cfg.enc == ENC_TWOS), {(W-1){1'b0}}};
      pick_a = (cfg.interleave && phase) ? word_b : word_a;
      bus_a  = pick_a ^ flip;
      bus_b  = word_b ^ flip;
      oe_b   = !cfg.interleave;
   end
endmodule

// File: rtl/adc_out_formatter.sv
module adc_out_formatter
   import adc_fmt_pkg::*;
#(
   parameter int W            = 14,
   parameter bit OVR_POS_WINS = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         smp_stb,
   input  logic [W-1:0] smp_a,
   input  logic         ovp_a,
   input  logic         ovn_a,
   input  logic [W-1:0] smp_b,
   input  logic         ovp_b,
   input  logic         ovn_b,
   input  logic         fmt_twos,
   input  logic         mux_en,
   output logic [W-1:0] bus_a,
   output logic [W-1:0] bus_b,
   output logic         bus_b_oe,
   output logic         mux_phase
);
   localparam int NCH = 2;

   generate
      if (W < 2) begin : g_bad_width
         $error("adc_out_formatter: W must be at least 2");
      end
   endgenerate

   logic [NCH-1:0][W-1:0] raw;
   logic [NCH-1:0]        opos;
   logic [NCH-1:0]        oneg;
   logic [NCH-1:0][W-1:0] clamped;
   logic [NCH-1:0][W-1:0] held;
   fmt_cfg_t              cfg_q;
   logic                  phase_q;

   assign raw  = {smp_b, smp_a};
   assign opos = {ovp_b, ovp_a};
   assign oneg = {ovn_b, ovn_a};

   genvar ch;
   generate
      for (ch = 0; ch < NCH; ch++) begin : g_ch
         cfmt_clamp #(.W(W), .OVR_POS_WINS(OVR_POS_WINS)) u_clamp (
            .raw     (raw[ch]),
            .ovr_pos (opos[ch]),
            .ovr_neg (oneg[ch]),
            .code    (clamped[ch])
         );
         cfmt_lane #(.W(W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (smp_stb),
            .d     (clamped[ch]),
            .q     (held[ch])
         );
      end
   endgenerate

   cfmt_ctrl u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .stb     (smp_stb),
      .fmt_in  (fmt_twos),
      .mux_in  (mux_en),
      .cfg_q   (cfg_q),
      .phase_q (phase_q)
   );

   cfmt_drive #(.W(W)) u_drive (
      .word_a (held[0]),
      .word_b (held[1]),
      .cfg    (cfg_q),
      .phase  (phase_q),
      .bus_a  (bus_a),
      .bus_b  (bus_b),
      .oe_b   (bus_b_oe)
   );

   assign mux_phase = phase_q;
endmodule

// File: rtl/cfmt_chk.sv
module cfmt_chk #(
   parameter int W            = 14,
   parameter bit OVR_POS_WINS = 1'b1
) (
   input logic         clk,
   input logic         rst_n,
   input logic         smp_stb,
   input logic         ovp_a,
   input logic         ovn_a,
   input logic         fmt_twos,
   input logic         mux_en,
   input logic [W-1:0] bus_a,
   input logic [W-1:0] bus_b,
   input logic         bus_b_oe,
   input logic         mux_phase
);
   localparam logic [W-1:0] OB_POS = {W{1'b1}};
   localparam logic [W-1:0] OB_NEG = {W{1'b0}};
   localparam logic [W-1:0] TC_POS = {1'b0, {(W-1){1'b1}}};
   localparam logic [W-1:0] TC_NEG = {1'b1, {(W-1){1'b0}}};

   // R1: normal mode with no strobe keeps both buses steady
   a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!smp_stb && bus_b_oe) |=> ($stable(bus_a) && $stable(bus_b) && bus_b_oe));

   a_r4_pos_fs: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && ovp_a && !ovn_a) |=> (bus_a == ($past(fmt_twos) ? TC_POS : OB_POS)));

   a_r5_neg_fs: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && ovn_a && !ovp_a) |=> (bus_a == ($past(fmt_twos) ? TC_NEG : OB_NEG)));

   a_r6_both_fs: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && ovn_a && ovp_a) |=>
         (bus_a == (OVR_POS_WINS ? ($past(fmt_twos) ? TC_POS : OB_POS)
                                 : ($past(fmt_twos) ? TC_NEG : OB_NEG))));

   a_r7_phase_a: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> !mux_phase);

   a_r7_phase_b: assert property (@(posedge clk) disable iff (!rst_n)
      (smp_stb && mux_en) ##1 !smp_stb |=> mux_phase);

   a_r8_oe: assert property (@(posedge clk) disable iff (!rst_n)
      smp_stb |=> (bus_b_oe == !$past(mux_en)));

   // R8 (normal mode): phase never rises while bus B is driven
   a_r8_normal_phase: assert property (@(posedge clk) disable iff (!rst_n)
      bus_b_oe |-> !mux_phase);
endmodule

bind adc_out_formatter cfmt_chk #(.W(W), .OVR_POS_WINS(OVR_POS_WINS)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .smp_stb   (smp_stb),
   .ovp_a     (ovp_a),
   .ovn_a     (ovn_a),
   .fmt_twos  (fmt_twos),
   .mux_en    (mux_en),
   .bus_a     (bus_a),
   .bus_b     (bus_b),
   .bus_b_oe  (bus_b_oe),
   .mux_phase (mux_phase)
);

// File: tb/adc_out_formatter_tb.sv
module adc_out_formatter_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0;
   logic [13:0] smp_a = '0;
   logic        ovp_a = 1'b0;
   logic        ovn_a = 1'b0;
   logic [13:0] smp_b = '0;
   logic        ovp_b = 1'b0;
   logic        ovn_b = 1'b0;
   logic        fmt_twos = 1'b0;
   logic        mux_en = 1'b0;
   logic [13:0] bus_a;
   logic [13:0] bus_b;
   logic        bus_b_oe;
   logic        mux_phase;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // reference model state
   int    m_a, m_b;
   bit    m_fmt, m_mux, m_ph;
   string r_a, r_b;

   always #10 clk = ~clk;

   adc_out_formatter u_dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
      .smp_a(smp_a), .ovp_a(ovp_a), .ovn_a(ovn_a),
      .smp_b(smp_b), .ovp_b(ovp_b), .ovn_b(ovn_b),
      .fmt_twos(fmt_twos), .mux_en(mux_en),
      .bus_a(bus_a), .bus_b(bus_b), .bus_b_oe(bus_b_oe), .mux_phase(mux_phase)
   );

   function automatic int sat(int s, bit p, bit n);
      if (p) return 16383;
      if (n) return 0;
      return s;
   endfunction

   function automatic string why(bit p, bit n, bit f);
      if (p && n) return "R6";
      if (p)      return "R4";
      if (n)      return "R5";
      return f ? "R3" : "R2";
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic cyc();
      @(posedge clk);
      if (!rst_n) begin
         m_fmt = fmt_twos; m_mux = mux_en; m_a = 8192; m_b = 8192; m_ph = 0;
         r_a = "R10"; r_b = "R10";
      end else if (smp_stb) begin
         m_fmt = fmt_twos; m_mux = mux_en; m_ph = 0;
         m_a = sat(int'(smp_a), ovp_a, ovn_a);
         m_b = sat(int'(smp_b), ovp_b, ovn_b);
         r_a = why(ovp_a, ovn_a, fmt_twos);
         r_b = why(ovp_b, ovn_b, fmt_twos);
      end else if (m_mux) begin
         m_ph = 1;
      end
      @(negedge clk);
      begin
         int    flip = m_fmt ? 8192 : 0;
         bit    cfg_moved = rst_n && (fmt_twos != m_fmt || mux_en != m_mux);
         string ta = (m_mux && m_ph) ? {r_b, "/R7"} : r_a;
         string tb = m_mux ? r_b : {r_b, "/R1"};
         if (cfg_moved) begin ta = {ta, "/R9"}; tb = {tb, "/R9"}; end
         chk(ta, int'(bus_a), ((m_mux && m_ph) ? m_b : m_a) ^ flip);
         if (!m_mux) chk(tb, int'(bus_b), m_b ^ flip);
         chk(cfg_moved ? "R8/R9" : "R8", int'(bus_b_oe), m_mux ? 0 : 1);
         chk(rst_n ? "R7" : "R10", int'(mux_phase), int'(m_ph));
      end
   endtask

   task automatic step(bit stb, int a, int b, bit pa, bit na, bit pb, bit nb);
      smp_stb = stb; smp_a = a[13:0]; smp_b = b[13:0];
      ovp_a = pa; ovn_a = na; ovp_b = pb; ovn_b = nb;
      cyc();
   endtask

   task automatic rnd_step(bit stb);
      int  r = int'($urandom);
      step(stb, int'($urandom % 16384), int'($urandom % 16384),
           (r % 7) == 3, (r % 5) == 2, (r % 6) == 1, (r % 4) == 3);
   endtask

   task automatic do_reset(bit f, bit m);
      rst_n = 0; fmt_twos = f; mux_en = m; smp_stb = 0;
      repeat (3) cyc();   // R10 checked while in reset
      rst_n = 1;
      cyc();
   endtask

   initial begin
      @(negedge clk);
      // R10: offset binary, normal mode
      do_reset(0, 0);
      // R1/R2: plain samples in normal mode
      step(1, 16'h0123, 16'h2ABC, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      // R4, R5, R6 in offset binary
      step(1, 100, 200, 1, 0, 0, 1);
      step(1, 100, 200, 1, 1, 1, 1);
      // R9: change format between strobes, then hold
      fmt_twos = 1;
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      // R3, R4, R5, R6 in two's complement
      step(1, 16'h1000, 16'h3000, 0, 0, 0, 0);
      step(1, 5, 6, 1, 0, 0, 1);
      step(1, 5, 6, 1, 1, 0, 0);
      for (int k = 0; k < 60; k++) rnd_step((k % 3) != 0);
      // R9: switch to interleaved mode between strobes
      mux_en = 1;
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      // R7/R8: interleaved with gap of several cycles
      step(1, 16'h0AAA, 16'h1555, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      // back-to-back strobes
      step(1, 16'h0001, 16'h0002, 0, 0, 1, 0);
      step(1, 16'h0003, 16'h0004, 0, 1, 0, 0);
      step(0, 0, 0, 0, 0, 0, 0);
      // random spacing in interleaved mode, both formats
      for (int k = 0; k < 80; k++) begin
         if (k == 40) fmt_twos = 0;
         rnd_step(($urandom % 3) == 0);
      end
      // R10: reset with two's complement and interleaved mode
      do_reset(1, 1);
      step(0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 40; k++) rnd_step((k % 2) == 0);
      // return to normal mode at a strobe
      mux_en = 0;
      step(0, 0, 0, 0, 0, 0, 0);
      for (int k = 0; k < 60; k++) begin
         if (k == 20) fmt_twos = 0;
         if (k == 45) mux_en = 1;
         rnd_step(($urandom % 2) == 0);
      end
      // R10: reset two's complement, normal mode
      do_reset(1, 0);
      for (int k = 0; k < 30; k++) rnd_step(1);
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule